// File: doc/BRIEF.md
# Single-Bit DRAM Record and Playback Controller

This block turns a 1M x 1 asynchronous DRAM into a one-bit loop recorder. After reset it takes one bit from a serial input in each sample slot and writes it to the next DRAM location. Once every location holds a sample, it switches for good to playback and reads the locations back in the same order, over and over, driving each bit to an output pin until the next reset.

The DRAM is reached over a multiplexed address bus with active-low row strobe, column strobe and write enable. Each slot runs a fixed order: a burst of CAS-before-RAS refresh cycles, then one read or write access, then a step of the 20-bit location counter. The row half of that counter moves first. Slots start on an external strobe or on an internal divider chosen by parameter. Each strobe phase lasts a parameterised number of clocks so the strobes meet the DRAM's row-to-column, column-pulse and precharge minimums. All pins toward the DRAM are registered.

Top module: `bitstream_dram_recorder`

## Requirements
- R1: After synchronous reset the row strobe, column strobe and write enable are high, busy is low, the mode output is 0 (record) and the address bus is 0; the strobes stay high while no slot runs.
- R2: Access number k (counted from 0 since reset, modulo the location count) uses row = k mod 2^ROW_W and column = k div 2^ROW_W: the row is on the bus when the row strobe falls, the column when the column strobe falls.
- R3: After 2^(ROW_W+COL_W) record slots the mode output becomes 1 (play) and stays 1 until reset; playback starts again from location 0 and wraps back to it after the last location.
- R4: A record access falls the row strobe with the row address, drives the data pin with the sample, drops write enable before the column strobe falls, and releases write enable while both strobes are still low, then the row strobe, then the column strobe.
- R5: A play access keeps write enable high, falls the row strobe then the column strobe, and moves the DRAM's data line, sampled while the column strobe is low, to the output pin.
- R6: In record mode the sample taken at the start of the slot is echoed to the output pin during the slot and held until the next slot.
- R7: Every slot issues exactly REF_PULSES CAS-before-RAS cycles (column strobe falls while the row strobe is high) before its access, and the refresh logic is idle during the access.
- R8: A slot starts only on a strobe pulse while no slot runs; strobe pulses that arrive during a running slot are held and, however many, start exactly one further slot as soon as the running slot ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 1 | Serial bit to record, taken at slot start |
| sample_stb | input | 1 | Slot request pulse (external-strobe variant) |
| dram_q | input | 1 | DRAM data output line |
| dram_addr | output | BUS_W | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_d | output | 1 | DRAM data input line |
| sample_out | output | 1 | Echoed or played-back bit |
| play_mode | output | 1 | 0 = record, 1 = play |
| busy | output | 1 | High while a slot runs |

## Verification
The assertions take for granted that reset is held for at least one clock at start and that sample_stb is a clean synchronous pulse; they make no assumption about its spacing, since a strobe during a busy slot must be absorbed. The stimulus reduces the address widths so that a full record pass and two playback passes fit in the run, raises the strobe only at falling clock edges, and once deliberately fires several strobes inside one slot to exercise the merge rule. The DRAM model in the bench trusts nothing about strobe order: it checks it at every edge of the strobes.

// File: rtl/bdr_pkg.sv
package bdr_pkg;

  typedef enum logic [1:0] {
    SL_IDLE,
    SL_REFRESH,
    SL_ACCESS,
    SL_ADVANCE
  } slot_state_t;

  typedef enum logic [2:0] {
    AX_ROW,
    AX_RAS,
    AX_COL,
    AX_CAS,
    AX_WEH,
    AX_RASH,
    AX_CASH
  } acc_step_t;

  // asserted-high view of the DRAM strobes for one access
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic col_sel;
  } strobe_t;

endpackage

// File: rtl/bdr_slot_timer.sv
module bdr_slot_timer #(
  parameter bit USE_EXT_STB = 1'b1,
  parameter int DIV_CYC     = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic stb_in,
  input  logic idle,
  output logic go
);
  logic trig;
  logic pending;

  generate
    if (USE_EXT_STB) begin : g_ext
      assign trig = stb_in;
    end else begin : g_div
      localparam int DW = $clog2(DIV_CYC) + 1;
      logic [DW-1:0] div_cnt;
      logic          unused_stb;
      assign unused_stb = stb_in;
      always_ff @(posedge clk) begin
        if (rst) div_cnt <= '0;
        else if (div_cnt == DW'(DIV_CYC - 1)) div_cnt <= '0;
        else div_cnt <= div_cnt + 1'b1;
      end
      assign trig = (div_cnt == DW'(DIV_CYC - 1));
    end
  endgenerate

  assign go = idle && pending;

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else pending <= (pending || trig) && !go;
  end

  // a slot leaves idle at once, so two starts never come back to back
  p_no_double_start_r8: assert property (@(posedge clk) disable iff (rst)
    go |=> !go);

endmodule

// File: rtl/bdr_refresh_seq.sv
module bdr_refresh_seq #(
  parameter int PH_CYC     = 2,
  parameter int REF_PULSES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ras,
  output logic cas,
  output logic done
);
  localparam int CW = $clog2(PH_CYC) + 1;
  localparam int PW = $clog2(REF_PULSES) + 1;

  logic          active;
  logic [1:0]    step;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pulse;
  logic          last_ph;
  logic          last_pulse;

  assign last_ph    = (cnt == CW'(PH_CYC - 1));
  assign last_pulse = (pulse == PW'(REF_PULSES - 1));

  // step 0: CAS low, 1: RAS low too, 2: CAS high, 3: both high
  assign cas  = active && (step == 2'd0 || step == 2'd1);
  assign ras  = active && (step == 2'd1 || step == 2'd2);
  assign done = active && step == 2'd3 && last_ph && last_pulse;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      step   <= '0;
      cnt    <= '0;
      pulse  <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        step   <= '0;
        cnt    <= '0;
        pulse  <= '0;
      end
    end else if (last_ph) begin
      cnt  <= '0;
      step <= step + 2'd1;
      if (step == 2'd3) begin
        if (last_pulse) active <= 1'b0;
        else pulse <= pulse + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bdr_access_seq.sv
module bdr_access_seq
  import bdr_pkg::*;
#(
  parameter int PH_CYC = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    wr,
  output strobe_t strb,
  output logic    echo,
  output logic    capture,
  output logic    done
);
  localparam int CW = $clog2(PH_CYC) + 1;

  logic          active;
  logic          wr_q;
  acc_step_t     step;
  acc_step_t     nxt;
  logic [CW-1:0] cnt;
  logic          last_ph;

  assign last_ph = (cnt == CW'(PH_CYC - 1));

  always_comb begin
    case (step)
      AX_ROW:  nxt = AX_RAS;
      AX_RAS:  nxt = AX_COL;
      AX_COL:  nxt = AX_CAS;
      AX_CAS:  nxt = wr_q ? AX_WEH : AX_RASH;
      AX_WEH:  nxt = AX_RASH;
      AX_RASH: nxt = AX_CASH;
      default: nxt = AX_CASH;
    endcase
  end

  always_comb begin
    strb.ras     = active && (step == AX_RAS || step == AX_COL ||
                              step == AX_CAS || step == AX_WEH);
    strb.cas     = active && (step == AX_CAS || step == AX_WEH || step == AX_RASH);
    strb.we      = active && wr_q && (step == AX_COL || step == AX_CAS);
    strb.col_sel = active && (step != AX_ROW && step != AX_RAS);
  end

  assign echo    = active && wr_q && step == AX_RAS && cnt == '0;
  assign capture = active && !wr_q && step == AX_RASH && cnt == '0;
  assign done    = active && step == AX_CASH && last_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      wr_q   <= 1'b0;
      step   <= AX_ROW;
      cnt    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        wr_q   <= wr;
        step   <= AX_ROW;
        cnt    <= '0;
      end
    end else if (last_ph) begin
      cnt <= '0;
      if (step == AX_CASH) active <= 1'b0;
      else step <= nxt;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/bdr_addr_counter.sv
module bdr_addr_counter #(
  parameter int ROW_W = 10,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             full
);
  localparam logic [ROW_W-1:0] ROW_MAX = '1;
  localparam logic [COL_W-1:0] COL_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      row  <= '0;
      col  <= '0;
      full <= 1'b0;
    end else if (inc) begin
      row <= row + 1'b1;
      if (row == ROW_MAX) begin
        col <= col + 1'b1;
        if (col == COL_MAX) full <= 1'b1;
      end
    end
  end

  p_col_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (inc && row != ROW_MAX) |=> $stable(col));

  p_full_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    full |=> full);

  p_wrap_to_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (inc && row == ROW_MAX && col == COL_MAX) |=> (full && row == '0 && col == '0));

endmodule

// File: rtl/bitstream_dram_recorder.sv
module bitstream_dram_recorder
  import bdr_pkg::*;
#(
  parameter int ROW_W       = 10,
  parameter int COL_W       = 10,
  parameter int BUS_W       = (ROW_W > COL_W) ? ROW_W : COL_W,
  parameter int PH_CYC      = 2,
  parameter int REF_PULSES  = 8,
  parameter bit USE_EXT_STB = 1'b1,
  parameter int DIV_CYC     = 4096
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_in,
  input  logic             sample_stb,
  input  logic             dram_q,
  output logic [BUS_W-1:0] dram_addr,
  output logic             dram_ras_n,
  output logic             dram_cas_n,
  output logic             dram_we_n,
  output logic             dram_d,
  output logic             sample_out,
  output logic             play_mode,
  output logic             busy
);
  slot_state_t      state;
  logic             go;
  logic             sample_q;
  logic             ref_start, ref_ras, ref_cas, ref_done;
  logic             acc_start, acc_echo, acc_capture, acc_done;
  strobe_t          acc_strb;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             full;

  assign ref_start = (state == SL_IDLE) && go;
  assign acc_start = (state == SL_REFRESH) && ref_done;

  bdr_slot_timer #(.USE_EXT_STB(USE_EXT_STB), .DIV_CYC(DIV_CYC)) u_timer (
    .clk(clk), .rst(rst), .stb_in(sample_stb),
    .idle(state == SL_IDLE), .go(go)
  );

  bdr_refresh_seq #(.PH_CYC(PH_CYC), .REF_PULSES(REF_PULSES)) u_refresh (
    .clk(clk), .rst(rst), .start(ref_start),
    .ras(ref_ras), .cas(ref_cas), .done(ref_done)
  );

  bdr_access_seq #(.PH_CYC(PH_CYC)) u_access (
    .clk(clk), .rst(rst), .start(acc_start), .wr(!full),
    .strb(acc_strb), .echo(acc_echo), .capture(acc_capture), .done(acc_done)
  );

  bdr_addr_counter #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
    .clk(clk), .rst(rst), .inc(state == SL_ADVANCE),
    .row(row), .col(col), .full(full)
  );

  // slot sequencer: refresh, access, advance
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SL_IDLE;
      sample_q <= 1'b0;
    end else begin
      case (state)
        SL_IDLE: if (go) begin
          sample_q <= sample_in;
          state    <= SL_REFRESH;
        end
        SL_REFRESH: if (ref_done) state <= SL_ACCESS;
        SL_ACCESS:  if (acc_done) state <= SL_ADVANCE;
        default:    state <= SL_IDLE;
      endcase
    end
  end

  // registered pin stage
  always_ff @(posedge clk) begin
    if (rst) begin
      dram_addr  <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_d     <= 1'b0;
      sample_out <= 1'b0;
      play_mode  <= 1'b0;
      busy       <= 1'b0;
    end else begin
      dram_addr  <= acc_strb.col_sel ? BUS_W'(col) : BUS_W'(row);
      dram_ras_n <= !(ref_ras || acc_strb.ras);
      dram_cas_n <= !(ref_cas || acc_strb.cas);
      dram_we_n  <= !acc_strb.we;
      dram_d     <= sample_q;
      play_mode  <= full;
      busy       <= (state != SL_IDLE);
      if (acc_echo) sample_out <= sample_q;
      else if (acc_capture) sample_out <= dram_q;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (state == SL_IDLE && $past(state) == SL_IDLE) |-> (dram_ras_n && dram_cas_n && dram_we_n));

  p_no_write_in_play_r3: assert property (@(posedge clk) disable iff (rst)
    play_mode |-> dram_we_n);

  p_we_under_ras_r4: assert property (@(posedge clk) disable iff (rst)
    !dram_we_n |-> !dram_ras_n);

  p_refresh_idle_in_access_r7: assert property (@(posedge clk) disable iff (rst)
    (state == SL_ACCESS) |-> (!ref_ras && !ref_cas));

endmodule

// File: tb/bitstream_dram_recorder_test.sv
module bitstream_dram_recorder_test;
  localparam int RW   = 3;
  localparam int CW   = 3;
  localparam int BW   = 3;
  localparam int NLOC = 1 << (RW + CW);
  localparam int PH   = 2;
  localparam int NREF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_in = 1'b0;
  logic sample_stb = 1'b0;
  logic dram_q = 1'b0;
  logic [BW-1:0] dram_addr;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_d;
  logic sample_out, play_mode, busy;

  int checks = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bitstream_dram_recorder #(
    .ROW_W(RW), .COL_W(CW), .PH_CYC(PH), .REF_PULSES(NREF), .USE_EXT_STB(1'b1)
  ) uut (
    .clk(clk), .rst(rst), .sample_in(sample_in), .sample_stb(sample_stb),
    .dram_q(dram_q), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_d(dram_d),
    .sample_out(sample_out), .play_mode(play_mode), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural DRAM with order checks ----------------
  logic mem [NLOC];
  logic [BW-1:0] lat_row;
  int acc_idx = 0;
  int cbr = 0;

  always @(negedge dram_ras_n) if (!rst && dram_cas_n) begin
    lat_row = dram_addr;
    chk(dram_addr == BW'((acc_idx % NLOC) % (1 << RW)), "R2", "row at RAS fall",
        dram_addr, (acc_idx % NLOC) % (1 << RW));
  end

  always @(negedge dram_cas_n) if (!rst) begin
    if (dram_ras_n) cbr++;
    else begin
      chk(cbr == NREF, "R7", "refresh cycles before access", cbr, NREF);
      cbr = 0;
      chk(dram_addr == BW'((acc_idx % NLOC) / (1 << RW)), "R2", "column at CAS fall",
          dram_addr, (acc_idx % NLOC) / (1 << RW));
      if (acc_idx < NLOC) begin
        chk(dram_we_n == 1'b0, "R4", "write enable low before CAS", dram_we_n, 0);
        mem[dram_addr * (1 << RW) + lat_row] = dram_d;
      end else begin
        chk(dram_we_n == 1'b1, "R5", "write enable high in play", dram_we_n, 1);
        dram_q = mem[dram_addr * (1 << RW) + lat_row];
      end
      acc_idx++;
    end
  end

  always @(posedge dram_cas_n) if (!rst) dram_q = 1'b0;

  always @(posedge dram_we_n) if (!rst)
    chk(!dram_ras_n && !dram_cas_n, "R4", "write enable released under both strobes",
        {dram_ras_n, dram_cas_n}, 0);

  // ---------------- scoreboard ----------------
  typedef struct { logic val; logic play; int idx; } exp_t;
  exp_t sbq[$];
  logic rec [NLOC];
  int slot_k = 0;
  int slots_seen = 0;
  logic busy_prev = 1'b0;

  task automatic push_exp(input logic s);
    exp_t e;
    if (slot_k < NLOC) begin
      rec[slot_k] = s;
      e.val = s;
    end else begin
      e.val = rec[slot_k % NLOC];
    end
    e.play = (slot_k >= NLOC - 1);
    e.idx = slot_k;
    sbq.push_back(e);
    slot_k++;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (!busy_prev && busy) slots_seen++;
      if (busy_prev && !busy) begin
        if (sbq.size() == 0) chk(0, "R8", "unexpected slot end", slots_seen, 0);
        else begin
          exp_t e;
          e = sbq.pop_front();
          chk(sample_out == e.val, e.idx < NLOC ? "R6" : "R5",
              $sformatf("output bit slot %0d", e.idx), sample_out, e.val);
          chk(play_mode == e.play, "R3", $sformatf("mode after slot %0d", e.idx),
              play_mode, e.play);
        end
      end
    end
    busy_prev <= busy;
  end

  // driver: one slot, optionally with extra strobes fired while busy
  task automatic do_slot(input logic s, input int extra);
    sample_in = s;
    push_exp(s);
    if (extra > 0) push_exp(s);
    @(negedge clk) sample_stb = 1'b1;
    @(negedge clk) sample_stb = 1'b0;
    while (!busy) @(negedge clk);
    for (int i = 0; i < extra; i++) begin
      @(negedge clk) sample_stb = 1'b1;
      @(negedge clk) sample_stb = 1'b0;
    end
    while (busy) @(negedge clk);
    if (extra > 0) begin
      @(negedge clk);
      while (busy) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes high after reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
    chk(play_mode == 1'b0, "R1", "mode after reset", play_mode, 0);
    chk(dram_addr == '0, "R1", "address after reset", dram_addr, 0);
    repeat (5) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && busy == 1'b0, "R8", "no slot without strobe",
        {dram_ras_n, dram_cas_n, busy}, 6);

    // record pass, one merged-strobe slot pair inside it (R8)
    while (slot_k < NLOC) begin
      logic s;
      s = logic'(((slot_k * 5 + 3) % 7) < 3);
      if (slot_k == 10) do_slot(s, 3);
      else do_slot(s, 0);
    end
    chk(play_mode == 1'b1, "R3", "play after full pass", play_mode, 1);

    // two playback passes; sample_in must not matter
    while (slot_k < 3 * NLOC) do_slot(logic'(slot_k & 1), 0);

    repeat (4) @(negedge clk);
    chk(slots_seen == slot_k, "R8", "slot count", slots_seen, slot_k);
    chk(sbq.size() == 0, "R8", "scoreboard drained", sbq.size(), 0);
    chk(acc_idx == slot_k, "R2", "access count", acc_idx, slot_k);
    chk(play_mode == 1'b1, "R3", "play held", play_mode, 1);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", slot_k, 3 * NLOC);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule